// File: doc/BRIEF.md
# Gapped Clock Pattern Generator

This block produces a clock-enable stream in the 51.84 MHz reference clock domain. It marks a cycle active or idle so that the average number of active cycles matches a slower tributary rate. The stream is built at three levels. Short minor patterns are bursts of active cycles, some with a single idle cycle after them. A major pattern plays a run of minor patterns, each repeated a set number of times. A super pattern plays major pattern A twice and then major pattern B once, and then starts again.

A downstream clock-gating cell or data sampler uses `gclk_en` as its qualifier. Three boundary strobes mark the final cycle of each minor, major and super pattern, so other logic can align to the sequence. Parameters set the repeat counts of pattern A. Pattern B keeps its fixed composition by default. `run` pauses the sequence without losing its position.

Top module: `gapclk_gen`

## Requirements
- R1: After `rst_n` is released with `run` high, the first reference cycle is the first active cycle of the first major pattern A, and no strobe is asserted.
- R2: Minor pattern P1 is 7 active cycles followed by 1 idle cycle (8 cycles).
- R3: Minor pattern P2 is 5 active cycles followed by 1 idle cycle (6 cycles).
- R4: Minor pattern P3 is 6 active cycles with no idle cycle (6 cycles).
- R5: Major pattern B plays P1 63 times, then P2 35 times, then P3 once: 622 active cycles in 720 running cycles.
- R6: Major pattern A plays P1, then P2, then P3, repeated `A_REP_P1`, `A_REP_P2` and `A_REP_P3` times. With the defaults 60/40/1 this gives 626 active cycles in 726 running cycles.
- R7: The super pattern is A, A, B, repeated without end: 1874 active cycles in 2172 running cycles per super pattern.
- R8: `minor_end`, `major_end` and `super_end` are each high for exactly the final running cycle of their pattern, and are low on every other cycle.
- R9: While `run` is low, `gclk_en` and all strobes are low and the sequence position is held. The next running cycle continues from the held position.
- R10: No two running cycles in a row are both idle, including across minor, major and super boundaries.
- R11: Reset is synchronous and active low. While `rst_n` is low, all outputs are low, and the sequence restarts at the beginning of A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 51.84 MHz reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Advance the sequence this cycle; when low, hold the position and force the outputs low |
| gclk_en | output | 1 | Gapped clock enable for the current cycle |
| minor_end | output | 1 | Final cycle of a minor pattern |
| major_end | output | 1 | Final cycle of a major pattern |
| super_end | output | 1 | Final cycle of a super pattern |

## Verification
All outputs are combinational in the held position and `run`. Every result is therefore due in the same cycle in which `run` is presented: zero cycles of latency. The position moves one step at the following rising edge. The bench drives inputs on the falling edge and samples 1 ns later. There it compares against an arithmetic model indexed by the number of running cycles since reset. That index advances only on sampled running cycles, so pauses never shift the expected value. Major and super totals are added up between strobes and compared when the strobe is seen.

// File: rtl/gapclk_pkg.sv
// Package: shared types and minor-pattern shapes for the gapped clock generator.
// Assumes every burst length is at least 1 and that burst plus gap fits in POS_W bits.
package gapclk_pkg;

    localparam int POS_W = 3;

    typedef enum logic [1:0] {
        MINOR_P1 = 2'd0,
        MINOR_P2 = 2'd1,
        MINOR_P3 = 2'd2
    } minor_e;

    typedef enum logic {
        MAJ_A = 1'b0,
        MAJ_B = 1'b1
    } major_e;

    // Number of active cycles in a minor pattern.
    function automatic logic [POS_W-1:0] burst_len(minor_e k);
        case (k)
            MINOR_P1: return POS_W'(7);
            MINOR_P2: return POS_W'(5);
            default:  return POS_W'(6);
        endcase
    endfunction

    // Whether an idle cycle follows the burst.
    function automatic logic has_gap(minor_e k);
        return (k != MINOR_P3);
    endfunction

endpackage

// File: rtl/gapclk_minor.sv
// Minor pattern player: walks one minor pattern cycle by cycle.
// Reports whether the current position is active and whether it is the final one.
// Assumes the kind input changes only at the edge where the pattern wraps.
module gapclk_minor
    import gapclk_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   adv,
    input  minor_e kind,
    output logic   en,
    output logic   last
);
    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] burst;
    logic [POS_W-1:0] final_pos;

    // Decode the shape of the current minor pattern.
    always_comb begin
        burst     = burst_len(kind);
        final_pos = has_gap(kind) ? burst : burst - POS_W'(1);
        en        = (pos_q < burst);
        last      = (pos_q == final_pos);
    end

    // Step the position within the minor pattern; wrap on its final cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pos_q <= '0;
        else if (adv)
            pos_q <= last ? '0 : pos_q + POS_W'(1);
    end

    // An idle cycle is always followed by an active one.
    assert_no_double_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !en) |=> en);

    // Position held when not advancing.
    assert_pos_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(pos_q));

endmodule

// File: rtl/gapclk_major.sv
// Major pattern sequencer: plays P1, P2 and P3, each repeated its own count.
// The count table is picked by the selected major pattern.
// Assumes every repeat count is at least 1 and fits in REP_W bits.
module gapclk_major
    import gapclk_pkg::*;
#(
    parameter int A_REP_P1 = 60,
    parameter int A_REP_P2 = 40,
    parameter int A_REP_P3 = 1,
    parameter int B_REP_P1 = 63,
    parameter int B_REP_P2 = 35,
    parameter int B_REP_P3 = 1
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   adv,
    input  major_e sel,
    input  logic   minor_last,
    output minor_e kind,
    output logic   major_last
);
    localparam int MAX_AB = (A_REP_P1 > B_REP_P1) ? A_REP_P1 : B_REP_P1;
    localparam int MAX_2  = (A_REP_P2 > B_REP_P2) ? A_REP_P2 : B_REP_P2;
    localparam int MAX_3  = (A_REP_P3 > B_REP_P3) ? A_REP_P3 : B_REP_P3;
    localparam int MAX_12 = (MAX_AB > MAX_2) ? MAX_AB : MAX_2;
    localparam int REP_MAX = (MAX_12 > MAX_3) ? MAX_12 : MAX_3;
    localparam int REP_W   = $clog2(REP_MAX + 1);
    localparam int NSEG    = 3;

    logic [1:0]       seg_q;
    logic [REP_W-1:0] rep_q;
    logic [REP_W-1:0] rep_lim;
    logic             seg_done;

    // Select the repeat count of the current segment for the selected major.
    always_comb begin
        case ({sel, seg_q})
            {MAJ_A, 2'd0}: rep_lim = REP_W'(A_REP_P1);
            {MAJ_A, 2'd1}: rep_lim = REP_W'(A_REP_P2);
            {MAJ_A, 2'd2}: rep_lim = REP_W'(A_REP_P3);
            {MAJ_B, 2'd0}: rep_lim = REP_W'(B_REP_P1);
            {MAJ_B, 2'd1}: rep_lim = REP_W'(B_REP_P2);
            default:       rep_lim = REP_W'(B_REP_P3);
        endcase
    end

    // Map segment to minor kind and flag the final cycle of the major pattern.
    always_comb begin
        case (seg_q)
            2'd0:    kind = MINOR_P1;
            2'd1:    kind = MINOR_P2;
            default: kind = MINOR_P3;
        endcase
        seg_done   = minor_last && (rep_q == rep_lim - REP_W'(1));
        major_last = seg_done && (seg_q == 2'(NSEG - 1));
    end

    // Count repeats and move to the next segment when a segment completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_q <= '0;
            rep_q <= '0;
        end else if (adv && minor_last) begin
            if (seg_done) begin
                rep_q <= '0;
                seg_q <= (seg_q == 2'(NSEG - 1)) ? 2'd0 : seg_q + 2'd1;
            end else begin
                rep_q <= rep_q + REP_W'(1);
            end
        end
    end

    // The repeat counter stays inside the count of the current segment.
    assert_rep_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rep_q < rep_lim);

    // After the final cycle of a major, the next one starts at the first P1.
    assert_major_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && major_last) |=> (seg_q == 2'd0 && rep_q == '0));

endmodule

// File: rtl/gapclk_gen.sv
// Gapped clock pattern generator top level.
// Sequences the super pattern (A repeated A_PLAYS times, then B) and gates the outputs with run and reset.
// Assumes the reference clock is the 51.84 MHz line rate and run is synchronous to it.
module gapclk_gen
    import gapclk_pkg::*;
#(
    parameter int A_REP_P1 = 60,
    parameter int A_REP_P2 = 40,
    parameter int A_REP_P3 = 1,
    parameter int A_PLAYS  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic gclk_en,
    output logic minor_end,
    output logic major_end,
    output logic super_end
);
    localparam int SUPER_LEN = A_PLAYS + 1;
    localparam int SP_W      = $clog2(SUPER_LEN);

    logic [SP_W-1:0] sp_q;
    major_e          sel;
    minor_e          kind;
    logic            m_en;
    logic            m_last;
    logic            maj_last;
    logic            sp_last;

    gapclk_minor u_minor (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (run),
        .kind  (kind),
        .en    (m_en),
        .last  (m_last)
    );

    gapclk_major #(
        .A_REP_P1 (A_REP_P1),
        .A_REP_P2 (A_REP_P2),
        .A_REP_P3 (A_REP_P3)
    ) u_major (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv        (run),
        .sel        (sel),
        .minor_last (m_last),
        .kind       (kind),
        .major_last (maj_last)
    );

    // Choose A for the first A_PLAYS majors, then B.
    always_comb begin
        sp_last = (sp_q == SP_W'(SUPER_LEN - 1));
        sel     = sp_last ? MAJ_B : MAJ_A;
    end

    // Step through the majors of the super pattern.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sp_q <= '0;
        else if (run && maj_last)
            sp_q <= sp_last ? '0 : sp_q + SP_W'(1);
    end

    // Gate the enable and the strobes with run and reset.
    always_comb begin
        gclk_en   = rst_n && run && m_en;
        minor_end = rst_n && run && m_last;
        major_end = rst_n && run && maj_last;
        super_end = rst_n && run && maj_last && sp_last;
    end

    // A super boundary is also a major and a minor boundary.
    assert_super_nest_R8: assert property (@(posedge clk) disable iff (!rst_n)
        super_end |-> (major_end && minor_end));

    // The super pattern restarts at the first A.
    assert_super_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        super_end |=> (sp_q == '0));

    // Paused: major position held.
    assert_pause_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(sp_q));

endmodule

// File: tb/sim_gapclk_gen.sv
`timescale 1ns/1ps
module sim_gapclk_gen;
    localparam int A1 = 60, A2 = 40, A3 = 1;
    localparam int B1 = 63, B2 = 35, B3 = 1;
    localparam int LEN_A = A1*8 + A2*6 + A3*6;
    localparam int LEN_B = B1*8 + B2*6 + B3*6;
    localparam int ENS_A = A1*7 + A2*5 + A3*6;
    localparam int ENS_B = B1*7 + B2*5 + B3*6;
    localparam int LEN_S = 2*LEN_A + LEN_B;
    localparam int ENS_S = 2*ENS_A + ENS_B;
    localparam int NCYC  = 8000;

    logic clk = 1'b0;
    logic rst_n, run;
    logic gclk_en, minor_end, major_end, super_end;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    gapclk_gen u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .gclk_en   (gclk_en),
        .minor_end (minor_end),
        .major_end (major_end),
        .super_end (super_end)
    );

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d (time %0t)", tag, what, act, exp, $time);
        end
    endtask

    // Expected outputs at running index t, from the requirements R2..R8.
    task automatic expect_at(input int t, output bit en, output bit mn, output bit mj,
                             output bit sp, output string tag);
        int u, o, k, c1, c2, len, r;
        u = t % LEN_S;
        if (u < LEN_A) begin k = 0; o = u; end
        else if (u < 2*LEN_A) begin k = 1; o = u - LEN_A; end
        else begin k = 2; o = u - 2*LEN_A; end
        c1  = (k == 2) ? B1 : A1;
        c2  = (k == 2) ? B2 : A2;
        len = (k == 2) ? LEN_B : LEN_A;
        if (o < c1*8) begin
            r = o % 8; en = (r < 7); mn = (r == 7); tag = "R2";
        end else if (o < c1*8 + c2*6) begin
            r = (o - c1*8) % 6; en = (r < 5); mn = (r == 5); tag = "R3";
        end else begin
            r = (o - c1*8 - c2*6) % 6; en = 1'b1; mn = (r == 5); tag = "R4";
        end
        mj = (o == len - 1);
        sp = mj && (k == 2);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int t, mk, acc_en, acc_per, sup_en, sup_per;
        bit prev_gap;
        bit e_en, e_mn, e_mj, e_sp;
        string tag;
        void'($urandom(32'd1234));
        rst_n = 1'b0; run = 1'b0;
        t = 0; mk = 0; acc_en = 0; acc_per = 0; sup_en = 0; sup_per = 0; prev_gap = 0;
        for (int i = 0; i < NCYC; i++) begin
            @(negedge clk);
            rst_n = !(i < 3 || (i >= 4000 && i < 4003));
            if (i < 60 || (i >= 4000 && i < 4020)) run = 1'b1;
            else run = (($urandom % 8) != 0);
            #1;
            if (!rst_n) begin
                // R11: outputs low during reset even with run high
                check("R11", "outputs in reset", {gclk_en, minor_end, major_end, super_end}, 0);
                t = 0; mk = 0; acc_en = 0; acc_per = 0; sup_en = 0; sup_per = 0; prev_gap = 0;
            end else if (!run) begin
                // R9: paused, all outputs low
                check("R9", "outputs paused", {gclk_en, minor_end, major_end, super_end}, 0);
            end else begin
                expect_at(t, e_en, e_mn, e_mj, e_sp, tag);
                if (t == 0) begin
                    // R1: restart at first active cycle of A, no strobe
                    check("R1", "first cycle enable", gclk_en, 1);
                    check("R1", "first cycle strobes", {minor_end, major_end, super_end}, 0);
                end
                check(tag, "gclk_en", gclk_en, e_en);
                check("R8", "minor_end", minor_end, e_mn);
                check("R8", "major_end", major_end, e_mj);
                check("R8", "super_end", super_end, e_sp);
                // R10: no two adjacent idle running cycles
                if (prev_gap) check("R10", "adjacent idle", gclk_en, 1);
                prev_gap = !gclk_en;
                acc_en += gclk_en; acc_per++;
                sup_en += gclk_en; sup_per++;
                if (major_end) begin
                    if (mk == 2) begin
                        check("R5", "B active count", acc_en, ENS_B);
                        check("R5", "B period count", acc_per, LEN_B);
                    end else begin
                        check("R6", "A active count", acc_en, ENS_A);
                        check("R6", "A period count", acc_per, LEN_A);
                    end
                    // R7: super boundary falls on the third major
                    check("R7", "super strobe position", super_end, (mk == 2) ? 1 : 0);
                    acc_en = 0; acc_per = 0;
                    mk = (mk + 1) % 3;
                end
                if (super_end) begin
                    check("R7", "super active count", sup_en, ENS_S);
                    check("R7", "super period count", sup_per, LEN_S);
                    sup_en = 0; sup_per = 0;
                end
                t++;
            end
        end
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule